// File: doc/BRIEF.md
# Low Memory Remap Address Translator

This block converts a page number as the memory controller sees it into the page number the system uses. Part of the address space below 4 GiB is taken by a hole, and the DRAM that would sit under that hole is moved to a window that starts above 4 GiB. Three 16-bit configuration registers describe the layout: the top of low memory, the base of the remap window and its limit. Each register is loaded from a shared write-data bus when its own write enable is high.

A page below the top of low memory is passed through unchanged. So is a page between 4 GiB (page 0x100000) and the remap base. Every other page is shifted by the distance between the remap base and the top of low memory. The shifted page is accepted only when it is strictly below the remap limit. When it is not, the block returns a fixed fallback page, raises an error flag and reports a region code. All arithmetic is unsigned modulo 2^32. The translation itself is combinational, and a parameter selects whether an output register follows it.

Top module: `remap_xlate`

## Requirements
- R1: While reset is low, and after it is released until the first load, all three configuration registers hold 0. The output register holds page 0, range_err 0 and region 0.
- R2: On a clock edge where tolm_we, base_we or limit_we is high, that register loads cfg_wdata. The top-of-low-memory page is the register value times 16 (shift left 4). The remap base and remap limit pages are their register values times 16384 (shift left 14).
- R3: A page strictly below the top-of-low-memory page is output unchanged with region code 0.
- R4: A page that is not covered by R3, is at least 0x100000 and is strictly below the remap base page is output unchanged with region code 1.
- R5: Any other page P is output as (P - top page + base page) modulo 2^32 with region code 2, provided that result is strictly below the limit page.
- R6: When the R5 result is equal to or above the limit page, the output is (top page - 1) modulo 2^32 and the region code is 3.
- R7: range_err is 1 exactly when the region code is 3.
- R8: With OUT_REG=1 (the default), the outputs show the translation of the page_in and configuration sampled at the previous rising edge, and they hold steady between edges. With OUT_REG=0 they follow the inputs in the same cycle.
- R9: A page presented in the same cycle as a configuration write is translated with the register values from before that write. The new value applies from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| cfg_wdata | input | 16 | Shared write data for the configuration registers |
| tolm_we | input | 1 | Load enable, top-of-low-memory register |
| base_we | input | 1 | Load enable, remap base register |
| limit_we | input | 1 | Load enable, remap limit register |
| page_in | input | 32 | Controller-side page number |
| page_out | output | 32 | Translated system page number |
| range_err | output | 1 | Relocated page fell at or above the remap limit |
| region | output | 2 | 0 low pass, 1 high pass, 2 relocated, 3 fault |

## Verification
A configuration write and a translation can fall in the same cycle. The bench provokes this by raising a write enable while page_in selects a page whose result depends on the register being written. The reference model, updated at each edge, decides the expected result from the register values held before that edge. A mismatch shows that the new value leaked into the translation early. The same run also drives pages onto each region boundary, including the remap limit itself, and a page high enough to wrap the 32-bit sum.

// File: rtl/remap_pkg.sv
package remap_pkg;

  localparam int unsigned PAGE_W = 32;
  localparam int unsigned NUM_CFG = 3;

  // indices into the configuration register bank
  localparam int unsigned CFG_TOLM  = 0;
  localparam int unsigned CFG_BASE  = 1;
  localparam int unsigned CFG_LIMIT = 2;

  typedef logic [PAGE_W-1:0] page_t;

  typedef enum logic [1:0] {
    RGN_LOW   = 2'd0,
    RGN_HIGH  = 2'd1,
    RGN_MOVED = 2'd2,
    RGN_FAULT = 2'd3
  } region_e;

  typedef struct packed {
    page_t   page;
    logic    err;
    region_e rgn;
  } xlate_res_t;

endpackage

// File: rtl/remap_cfg_bank.sv
module remap_cfg_bank
  import remap_pkg::*;
#(
  parameter int unsigned CFG_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CFG-1:0]       we,
  input  logic [CFG_W-1:0]         wdata,
  output logic [NUM_CFG-1:0][CFG_W-1:0] q
);

  logic [NUM_CFG-1:0][CFG_W-1:0] q_r;
  logic [NUM_CFG-1:0][CFG_W-1:0] q_nxt;

  for (genvar gi = 0; gi < NUM_CFG; gi++) begin : g_reg
    always_comb begin
      q_nxt[gi] = q_r[gi];
      if (we[gi]) begin
        q_nxt[gi] = wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_r[gi] <= '0;
      end else if (we[gi]) begin
        q_r[gi] <= q_nxt[gi];
      end
    end
  end

  assign q = q_r;

endmodule

// File: rtl/remap_xlate_core.sv
module remap_xlate_core
  import remap_pkg::*;
#(
  parameter int unsigned CFG_W      = 16,
  parameter int unsigned TOLM_SH    = 4,
  parameter int unsigned WIN_SH     = 14,
  parameter logic [31:0] HIGH_START = 32'h0010_0000
) (
  input  logic [CFG_W-1:0] tolm_cfg,
  input  logic [CFG_W-1:0] base_cfg,
  input  logic [CFG_W-1:0] limit_cfg,
  input  page_t            page_in,
  output page_t            tolm_pg,
  output page_t            base_pg,
  output page_t            lim_pg,
  output xlate_res_t       res
);

  localparam int unsigned TOLM_PAD = PAGE_W - CFG_W - TOLM_SH;
  localparam int unsigned WIN_PAD  = PAGE_W - CFG_W - WIN_SH;

  page_t hi_start;
  page_t moved_pg;
  page_t fallback_pg;
  logic  in_low;
  logic  in_high;
  logic  moved_ok;

  assign hi_start = page_t'(HIGH_START);

  // scale register values into page numbers
  assign tolm_pg = {{TOLM_PAD{1'b0}}, tolm_cfg,  {TOLM_SH{1'b0}}};
  assign base_pg = {{WIN_PAD{1'b0}},  base_cfg,  {WIN_SH{1'b0}}};
  assign lim_pg  = {{WIN_PAD{1'b0}},  limit_cfg, {WIN_SH{1'b0}}};

  // region decode
  assign in_low  = (page_in < tolm_pg);
  assign in_high = (page_in >= hi_start) && (page_in < base_pg);

  // relocation path, wraps modulo 2^PAGE_W
  assign moved_pg    = (page_in - tolm_pg) + base_pg;
  assign moved_ok    = (moved_pg < lim_pg);
  assign fallback_pg = tolm_pg - page_t'(1);

  always_comb begin
    res.page = page_in;
    res.err  = 1'b0;
    res.rgn  = RGN_LOW;
    if (in_low) begin
      res.rgn = RGN_LOW;
    end else if (in_high) begin
      res.rgn = RGN_HIGH;
    end else if (moved_ok) begin
      res.page = moved_pg;
      res.rgn  = RGN_MOVED;
    end else begin
      res.page = fallback_pg;
      res.err  = 1'b1;
      res.rgn  = RGN_FAULT;
    end
  end

endmodule

// File: rtl/remap_out_stage.sv
module remap_out_stage
  import remap_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  xlate_res_t res_in,
  output xlate_res_t res_out
);

  if (OUT_REG) begin : g_reg
    xlate_res_t res_q;
    xlate_res_t res_nxt;

    always_comb begin
      res_nxt = res_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_q.page <= '0;
        res_q.err  <= 1'b0;
        res_q.rgn  <= RGN_LOW;
      end else begin
        res_q <= res_nxt;
      end
    end

    assign res_out = res_q;
  end else begin : g_comb
    assign res_out = res_in;
  end

endmodule

// File: rtl/remap_xlate.sv
module remap_xlate
  import remap_pkg::*;
#(
  parameter int unsigned CFG_W      = 16,
  parameter int unsigned TOLM_SH    = 4,
  parameter int unsigned WIN_SH     = 14,
  parameter logic [31:0] HIGH_START = 32'h0010_0000,
  parameter bit          OUT_REG    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              tolm_we,
  input  logic              base_we,
  input  logic              limit_we,
  input  logic [31:0]       page_in,
  output logic [31:0]       page_out,
  output logic              range_err,
  output logic [1:0]        region
);

  logic [NUM_CFG-1:0]            cfg_we;
  logic [NUM_CFG-1:0][CFG_W-1:0] cfg_q;
  page_t                         tolm_pg;
  page_t                         base_pg;
  page_t                         lim_pg;
  xlate_res_t                    xl_res;
  xlate_res_t                    out_res;

  always_comb begin
    cfg_we            = '0;
    cfg_we[CFG_TOLM]  = tolm_we;
    cfg_we[CFG_BASE]  = base_we;
    cfg_we[CFG_LIMIT] = limit_we;
  end

  remap_cfg_bank #(
    .CFG_W (CFG_W)
  ) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .q     (cfg_q)
  );

  remap_xlate_core #(
    .CFG_W      (CFG_W),
    .TOLM_SH    (TOLM_SH),
    .WIN_SH     (WIN_SH),
    .HIGH_START (HIGH_START)
  ) u_core (
    .tolm_cfg  (cfg_q[CFG_TOLM]),
    .base_cfg  (cfg_q[CFG_BASE]),
    .limit_cfg (cfg_q[CFG_LIMIT]),
    .page_in   (page_in),
    .tolm_pg   (tolm_pg),
    .base_pg   (base_pg),
    .lim_pg    (lim_pg),
    .res       (xl_res)
  );

  remap_out_stage #(
    .OUT_REG (OUT_REG)
  ) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .res_in  (xl_res),
    .res_out (out_res)
  );

  assign page_out  = out_res.page;
  assign range_err = out_res.err;
  assign region    = out_res.rgn;

endmodule

// File: rtl/remap_xlate_chk.sv
module remap_xlate_chk
  import remap_pkg::*;
#(
  parameter int unsigned CFG_W   = 16,
  parameter bit          OUT_REG = 1'b1
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [NUM_CFG-1:0]            cfg_we,
  input logic [CFG_W-1:0]              cfg_wdata,
  input logic [NUM_CFG-1:0][CFG_W-1:0] cfg_q,
  input page_t                         page_in,
  input page_t                         tolm_pg,
  input page_t                         base_pg,
  input page_t                         lim_pg,
  input xlate_res_t                    xl_res,
  input page_t                         page_out,
  input logic                          range_err,
  input logic [1:0]                    region
);

  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      past_ok <= 1'b0;
    end else begin
      past_ok <= 1'b1;
    end
  end

  for (genvar gi = 0; gi < NUM_CFG; gi++) begin : g_cfg
    // R2
    cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we[gi] |=> (cfg_q[gi] == $past(cfg_wdata)));
    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we[gi] |=> $stable(cfg_q[gi]));
  end

  // R3
  low_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (page_in < tolm_pg) |-> (xl_res.rgn == RGN_LOW && xl_res.page == page_in));

  // R4
  high_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_res.rgn == RGN_HIGH) |-> (xl_res.page == page_in && page_in < base_pg));

  // R5
  moved_below_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_res.rgn == RGN_MOVED) |-> (xl_res.page < lim_pg));

  // R6
  fault_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_res.rgn == RGN_FAULT) |-> (xl_res.page + page_t'(1) == tolm_pg));

  // R7
  err_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    range_err == (region == 2'd3));

  if (OUT_REG) begin : g_lat
    // R8
    out_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (page_out == $past(xl_res.page) && region == $past(xl_res.rgn)));
  end else begin : g_nolat
    // R8
    out_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (page_out == xl_res.page && region == xl_res.rgn));
  end

endmodule

bind remap_xlate remap_xlate_chk #(
  .CFG_W   (CFG_W),
  .OUT_REG (OUT_REG)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_wdata (cfg_wdata),
  .cfg_q     (cfg_q),
  .page_in   (page_in),
  .tolm_pg   (tolm_pg),
  .base_pg   (base_pg),
  .lim_pg    (lim_pg),
  .xl_res    (xl_res),
  .page_out  (page_out),
  .range_err (range_err),
  .region    (region)
);

// File: tb/remap_xlate_bench.sv
module remap_xlate_bench;

  logic        clk;
  logic        rst_n;
  logic [15:0] cfg_wdata;
  logic        tolm_we;
  logic        base_we;
  logic        limit_we;
  logic [31:0] page_in;
  logic [31:0] page_out;
  logic        range_err;
  logic [1:0]  region;

  int n_checks = 0;
  int n_fail   = 0;
  bit cmp_on   = 0;
  bit finished = 0;

  remap_xlate u_remap_xlate (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wdata (cfg_wdata),
    .tolm_we   (tolm_we),
    .base_we   (base_we),
    .limit_we  (limit_we),
    .page_in   (page_in),
    .page_out  (page_out),
    .range_err (range_err),
    .region    (region)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // reference model state
  longint m_tolm, m_base, m_lim;
  longint e_page;
  bit     e_err;
  int     e_rgn;
  string  e_tag;

  localparam longint MASK32 = 64'hFFFF_FFFF;

  task automatic check(input string tag, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // behavioural translation on register values held before this edge
  always @(posedge clk) begin
    longint tp, bp, lp, p, r;
    string tg;
    if (!rst_n) begin
      m_tolm = 0; m_base = 0; m_lim = 0;
      e_page = 0; e_err = 0; e_rgn = 0; e_tag = "R1";
    end else begin
      tp = m_tolm * 16;
      bp = m_base * 16384;
      lp = m_lim * 16384;
      p  = longint'(page_in);
      if (p < tp) begin
        e_page = p; e_rgn = 0; e_err = 0; tg = "R3";
      end else if (p >= 64'h10_0000 && p < bp) begin
        e_page = p; e_rgn = 1; e_err = 0; tg = "R4";
      end else begin
        r = (p - tp + bp) & MASK32;
        if (r < lp) begin
          e_page = r; e_rgn = 2; e_err = 0; tg = "R5";
        end else begin
          e_page = (tp - 1) & MASK32; e_rgn = 3; e_err = 1; tg = "R6";
        end
      end
      if (tolm_we || base_we || limit_we) tg = {tg, "/R9"};
      e_tag = tg;
      if (tolm_we)  m_tolm = longint'(cfg_wdata);
      if (base_we)  m_base = longint'(cfg_wdata);
      if (limit_we) m_lim  = longint'(cfg_wdata);
    end
  end

  // per-clock comparison away from the active edge
  always @(negedge clk) begin
    if (cmp_on && !finished) begin
      check({e_tag, " page_out"}, longint'(page_out), e_page);
      check({e_tag, " region"}, longint'(region), longint'(e_rgn));
      check("R7 range_err", longint'(range_err), longint'(e_err));
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic drive_page(input logic [31:0] p);
    longint held;
    step();
    held = e_page;
    page_in = p;
    #1;
    // R8: output must not follow page_in before the next edge
    check("R8 hold until edge", longint'(page_out), held);
  endtask

  task automatic write_cfg(input int sel, input logic [15:0] d, input logic [31:0] p);
    step();
    cfg_wdata = d;
    page_in   = p;
    tolm_we   = (sel == 0);
    base_we   = (sel == 1);
    limit_we  = (sel == 2);
    step();
    tolm_we = 0; base_we = 0; limit_we = 0;
  endtask

  // watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_wdata = 0; tolm_we = 0; base_we = 0; limit_we = 0;
    page_in = 32'h0001_2345;
    repeat (3) @(posedge clk);
    #3;
    // R1: reset state of the output register
    check("R1 page_out", longint'(page_out), 0);
    check("R1 region", longint'(region), 0);
    check("R1 range_err", longint'(range_err), 0);
    @(posedge clk);
    #2;
    rst_n = 1;
    cmp_on = 1;
    // all registers zero: page 0 overflows the zero limit, fallback wraps
    drive_page(32'h0);
    drive_page(32'h0);

    // R2: program the layout
    write_cfg(0, 16'hC000, 32'h0);
    write_cfg(1, 16'h0044, 32'h0);
    write_cfg(2, 16'h0054, 32'h0);

    // R3 and region boundaries
    drive_page(32'h0000_0000);
    drive_page(32'h000B_FFFF);
    drive_page(32'h000C_0000);   // R5 first moved page
    drive_page(32'h000F_FFFF);   // R5 lands one below the limit
    drive_page(32'h0010_0000);   // R4
    drive_page(32'h0010_FFFF);   // R4 last high page
    drive_page(32'h0011_0000);   // R6 at base, moved beyond limit
    drive_page(32'hFFFF_FFFF);   // R5 wraps modulo 2^32

    // base at 4 GiB: empty high window, limit boundary exactly hit
    write_cfg(1, 16'h0040, 32'h000C_0000);
    drive_page(32'h0010_FFFF);   // R5 result limit-1
    drive_page(32'h0011_0000);   // R6 result equals limit

    // R9: write in the same cycle as a dependent page
    write_cfg(0, 16'hD000, 32'h000C_8000);  // old tolm: relocated
    drive_page(32'h000C_8000);              // new tolm: low pass
    write_cfg(2, 16'h0000, 32'h000D_0000);  // old limit: relocated
    drive_page(32'h000D_0000);              // zero limit: fault
    drive_page(32'h0000_1000);

    step();
    step();
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule